// File: doc/BRIEF.md
# Prescaled Reloadable Periodic Timer

This block is a periodic timer that runs from a slow reference. The reference is presented to it as a one-cycle enable strobe in the system clock domain. A power-of-two prescaler divides that strobe by 2^code. Each divided tick decrements a down-counter. When the counter passes zero it loads itself again from a reload register and raises a one-cycle expiry pulse. The divided tick also leaves the block as a one-cycle strobe, so that a downstream watchdog stage can count on the same time base.

Software drives the timer through four word registers. Writing the restart bit in the control/status register arms a reload. The reload completes on the second reference strobe after the write, which stands in for crossing into the slow domain. Until then the restart bit reads back as 1. The same register holds a sticky watchdog-reset flag that is cleared by writing 1, so a read-modify-write that writes 0 to it leaves it untouched.

The timer is idle after reset and starts counting at the first completed restart.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset, every register reads 0, and `presc_tick` and `expire` are low.
- R2: Address 1 bits [2:0] hold the prescale code c. Once the timer runs, `presc_tick` is high for one cycle, in the cycle after every 2^c-th reference strobe counted from the restart load. The strobe count starts at the strobe after the load.
- R3: Address 2 holds the reload value N. Address 3 reads the current count. The count equals N right after a load, drops by one on each prescaled tick, and goes back to N on the tick after it reaches 0, so the expiry period is N+1 ticks.
- R4: `expire` is high for exactly one cycle, two cycles after the reference strobe that produced the expiring tick, and is low otherwise.
- R5: Writing 1 to bit 0 of address 0 sets the restart bit, which reads back as 1. The load takes place on the second reference strobe after the write, and the bit then clears by itself. A strobe that falls in the write cycle does not count. Writing 0 to the bit has no effect, and writing 1 while a restart is pending does not postpone the load.
- R6: Before the first restart completes, no reference strobe produces `presc_tick` or `expire`. Bit 2 of address 0 reads 1 once the timer is running.
- R7: Bit 1 of address 0 is set by a `wdog_evt` pulse. Writing 1 to it clears it, and writing 0 leaves it as it is. A set in the same cycle as a clear wins.
- R8: Writes to address 3 have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock period (strobes at least two cycles apart) |
| wdog_evt | input | 1 | Pulse that sets the watchdog-reset flag |
| wr_en | input | 1 | Register write enable |
| addr | input | 2 | Register address for both read and write |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for `addr` |
| presc_tick | output | 1 | Prescaled tick strobe exported to the watchdog stage |
| expire | output | 1 | One-cycle expiry event |

## Verification
The bench sends one reference strobe every four cycles. Within each window it samples at fixed offsets from that strobe: `presc_tick` one cycle after the strobe, and `expire` and the count two cycles after it. At three cycles it checks that `expire` is low again. The expected tick, count and expiry values come from the number of strobes seen since the load. The load is always expected on the second strobe after the restart write, and the restart bit is read between those two strobes.

// File: rtl/ptt_pkg.sv
// Package for the periodic tick timer.
// It holds the register address codes and the bit positions in the control/status word.
package ptt_pkg;
    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_PRESC  = 2'd1,
        REG_RELOAD = 2'd2,
        REG_COUNT  = 2'd3
    } reg_addr_e;

    localparam int CTRL_RESTART_BIT = 0;
    localparam int CTRL_WDFLAG_BIT  = 1;
    localparam int CTRL_RUN_BIT     = 2;
endpackage

// File: rtl/ptt_prescaler.sv
// Power-of-two prescaler.
// It counts reference strobes and sends out a registered one-cycle tick on every
// 2^code-th strobe. Assumes that ref_i pulses are single cycles. clr_i restarts the
// division, and the strobe that arrives together with clr_i produces no tick.
// Ticks come only while run_i is high.
module ptt_prescaler #(
    parameter int CODE_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ref_i,
    input  logic              clr_i,
    input  logic              run_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);
    localparam int PS_W = (1 << CODE_W) - 1;
    localparam logic [PS_W-1:0] PS_ONE = PS_W'(1);

    logic [PS_W-1:0] pcnt_q;
    logic [PS_W-1:0] mask;
    logic            hit;

    // Low-bit mask of the code width; the top code wraps round to all ones.
    always_comb begin
        mask = (PS_ONE << code_i) - PS_ONE;
        hit  = ((pcnt_q & mask) == mask);
    end

    // Strobe counter and the registered tick.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pcnt_q <= '0;
            tick_o <= 1'b0;
        end else if (clr_i) begin
            pcnt_q <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= ref_i && run_i && hit;
            if (ref_i) pcnt_q <= pcnt_q + PS_ONE;
        end
    end

    a_r2_tick_after_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> $past(ref_i));
endmodule

// File: rtl/ptt_restart_sync.sv
// Restart handshake.
// A request arms pending_o. The first reference strobe after the request marks
// the first stage. The second strobe gives a load pulse in its own cycle and
// clears pending_o. A request that arrives while pending_o is high is ignored.
module ptt_restart_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic ref_i,
    output logic pending_o,
    output logic load_o
);
    logic seen_q;

    // The load fires on the second strobe after the request.
    assign load_o = pending_o && ref_i && seen_q;

    // Pending flag and strobe stage.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pending_o <= 1'b0;
            seen_q    <= 1'b0;
        end else if (!pending_o) begin
            if (req_i) begin
                pending_o <= 1'b1;
                seen_q    <= 1'b0;
            end
        end else if (ref_i) begin
            if (seen_q) pending_o <= 1'b0;
            seen_q <= 1'b1;
        end
    end

    a_r5_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pending_o && ref_i && seen_q) |=> !pending_o);
    a_r5_restart_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pending_o && !(ref_i && seen_q)) |=> pending_o);
endmodule

// File: rtl/ptt_downcounter.sv
// Reloadable down-counter.
// A load copies the reload value and sets the run flag. Each tick while running
// decrements the count. A tick at zero reloads the count and raises a registered
// one-cycle expiry pulse.
module ptt_downcounter #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             run_o,
    output logic             expire_o
);
    // Count, run flag and expiry pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            count_o  <= '0;
            run_o    <= 1'b0;
            expire_o <= 1'b0;
        end else begin
            expire_o <= 1'b0;
            if (load_i) begin
                count_o <= reload_i;
                run_o   <= 1'b1;
            end else if (run_o && tick_i) begin
                if (count_o == '0) begin
                    count_o  <= reload_i;
                    expire_o <= 1'b1;
                end else begin
                    count_o <= count_o - CNT_W'(1);
                end
            end
        end
    end

    a_r3_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(load_i) |-> (count_o == $past(reload_i)));
    a_r4_expire_from_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |-> ($past(tick_i) && ($past(count_o) == '0)));
endmodule

// File: rtl/periodic_tick_timer.sv
// Prescaled reloadable periodic timer (top).
// It holds the register file: control/status, prescale code, reload value and a
// read-only count. It ties together the prescaler, the restart handshake and the
// down-counter. Assumes that ref_tick strobes are one cycle wide and at least two
// cycles apart. Reads are combinational on addr.
module periodic_tick_timer #(
    parameter int CNT_W  = 16,
    parameter int CODE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             wdog_evt,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rd_data,
    output logic             presc_tick,
    output logic             expire
);
    import ptt_pkg::*;

    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  reload_q;
    logic [CNT_W-1:0]  count;
    logic              wdflag_q;
    logic              pending;
    logic              load;
    logic              running;
    logic              wr_ctrl;
    logic              restart_req;

    assign wr_ctrl     = wr_en && (addr == REG_CTRL);
    assign restart_req = wr_ctrl && wdata[CTRL_RESTART_BIT];

    // Writable configuration registers; the count address takes no write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q   <= '0;
            reload_q <= '0;
        end else if (wr_en) begin
            if (addr == REG_PRESC)  code_q   <= wdata[CODE_W-1:0];
            if (addr == REG_RELOAD) reload_q <= wdata;
        end
    end

    // Sticky watchdog-reset flag, cleared by writing 1; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   wdflag_q <= 1'b0;
        else if (wdog_evt)                            wdflag_q <= 1'b1;
        else if (wr_ctrl && wdata[CTRL_WDFLAG_BIT])   wdflag_q <= 1'b0;
    end

    // Read mux.
    always_comb begin
        unique case (addr)
            REG_CTRL:   rd_data = {{(CNT_W-3){1'b0}}, running, wdflag_q, pending};
            REG_PRESC:  rd_data = {{(CNT_W-CODE_W){1'b0}}, code_q};
            REG_RELOAD: rd_data = reload_q;
            default:    rd_data = count;
        endcase
    end

    ptt_restart_sync u_sync (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .req_i     (restart_req),
        .ref_i     (ref_tick),
        .pending_o (pending),
        .load_o    (load)
    );

    ptt_prescaler #(.CODE_W(CODE_W)) u_presc (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .ref_i  (ref_tick),
        .clr_i  (load),
        .run_i  (running),
        .code_i (code_q),
        .tick_o (presc_tick)
    );

    ptt_downcounter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .load_i   (load),
        .tick_i   (presc_tick),
        .reload_i (reload_q),
        .count_o  (count),
        .run_o    (running),
        .expire_o (expire)
    );

    a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_evt |=> wdflag_q);
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!presc_tick && !expire));
endmodule

// File: tb/periodic_tick_timer_test.sv
module periodic_tick_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        wdog_evt = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rd_data;
    logic        presc_tick;
    logic        expire;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    periodic_tick_timer uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wdog_evt(wdog_evt),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_data(rd_data),
        .presc_tick(presc_tick), .expire(expire)
    );

    task automatic chk(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        addr = a;
        #1;
        v = int'(rd_data);
    endtask

    // Write at a negative edge; the write takes effect at the next rising edge.
    task automatic wr(input logic [1:0] a, input int v);
        addr = a; wdata = 16'(v); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    // One four-cycle reference window: strobe, +1, +2 and +3 cycles.
    task automatic ref_window(output int p, output int e1, output int e2, output int e3,
                              output int cnt, output int ctl);
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
        p = int'(presc_tick); e1 = int'(expire);
        rd(2'd0, ctl);
        @(negedge clk);
        e2 = int'(expire);
        rd(2'd3, cnt);
        @(negedge clk);
        e3 = int'(expire);
        @(negedge clk);
    endtask

    task automatic run_cfg(input int c, input int n, input bit dup);
        int d, total, p, e1, e2, e3, cnt, ctl, k, j;
        d = 1 << c;
        wr(2'd1, c);
        wr(2'd2, n);
        wr(2'd0, 1);
        total = 2 + 2 * (n + 1) * d;
        for (int i = 1; i <= total; i++) begin
            if (dup && i == 2) wr(2'd0, 1);  // R5: second restart while pending is ignored
            ref_window(p, e1, e2, e3, cnt, ctl);
            if (i == 1) begin
                chk("R5 restart bit pending", ctl & 1, 1);
            end else begin
                j = i - 2;
                k = j / d;
                if (i == 2) chk("R5 restart bit self-clears", ctl & 1, 0);
                if (i == 2) chk("R6 running flag", (ctl >> 2) & 1, 1);
                chk("R2 prescaled tick", p, (j > 0 && j % d == 0) ? 1 : 0);
                chk("R4 expire low at +1", e1, 0);
                chk("R4 expire at +2", e2, (j > 0 && j % (d * (n + 1)) == 0) ? 1 : 0);
                chk("R4 expire low at +3", e3, 0);
                chk("R3 count", cnt, n - (k % (n + 1)));
            end
        end
    endtask

    initial begin
        #1_600_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int v, p, e1, e2, e3, cnt, ctl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 register reset", v, 0);
        end
        chk("R1 presc_tick reset", int'(presc_tick), 0);
        chk("R1 expire reset", int'(expire), 0);
        // R6: idle before the first restart
        wr(2'd2, 0);
        for (int i = 0; i < 4; i++) begin
            ref_window(p, e1, e2, e3, cnt, ctl);
            chk("R6 no tick while idle", p, 0);
            chk("R6 no expire while idle", e2, 0);
        end
        // R5: writing 0 to the restart bit does nothing
        wr(2'd0, 0);
        rd(2'd0, v);
        chk("R5 write 0 no restart", v & 1, 0);
        // R7: watchdog flag behaviour
        wdog_evt = 1'b1; @(negedge clk); wdog_evt = 1'b0;
        rd(2'd0, v); chk("R7 flag set", (v >> 1) & 1, 1);
        wr(2'd0, 0);
        rd(2'd0, v); chk("R7 write 0 keeps flag", (v >> 1) & 1, 1);
        wr(2'd0, 2);
        rd(2'd0, v); chk("R7 write 1 clears flag", (v >> 1) & 1, 0);
        wdog_evt = 1'b1; wr(2'd0, 2); wdog_evt = 1'b0;
        rd(2'd0, v); chk("R7 set wins over clear", (v >> 1) & 1, 1);
        wr(2'd0, 2);
        rd(2'd1, v); chk("R2 code readback", v, 0);
        // Sweep of prescale codes and reload values, each restarted while running
        run_cfg(0, 0, 1'b1);
        for (int c = 0; c < 4; c++) begin
            run_cfg(c, 0, 1'b0);
            run_cfg(c, 1, 1'b0);
            run_cfg(c, 2, 1'b0);
            run_cfg(c, 5, 1'b0);
        end
        run_cfg(5, 1, 1'b0);
        rd(2'd1, v); chk("R2 code readback", v, 5);
        rd(2'd2, v); chk("R3 reload readback", v, 1);
        // R8: writes to the count address are ignored
        rd(2'd3, cnt);
        wr(2'd3, 16'h1234);
        rd(2'd3, v); chk("R8 count write ignored", v, cnt);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule